// File: doc/BRIEF.md
# Fixed-Length Branch Classifier

This block looks at one 32-bit instruction word of a fixed-length instruction set together with the 32-bit address it was fetched from. From those two values it works out a small set of facts about the word:

- whether it changes the program flow with an immediate offset (direct) or through a register or memory value (indirect);
- whether it is a call that saves a return address;
- whether it is a likely procedure return;
- whether it is predicated on a condition code;
- which memory barrier, if any, it is.

For direct branches it also computes the destination address. A trace decoder or a fetch-side predictor can use these facts to cut a stream of words into basic blocks without executing anything.

The decode is a combinational mask-and-compare tree. One output register stage sits behind it, under a two-state emit machine. `ST_IDLE` means no result is presented. `ST_EMIT` means the registered result belongs to the word accepted on the previous edge. The transitions are:

- `ST_IDLE` goes to `ST_EMIT` on an edge with `in_valid` high, and stays in `ST_IDLE` otherwise.
- `ST_EMIT` stays in `ST_EMIT` on an edge with `in_valid` high, so back-to-back words stream with no gap.
- `ST_EMIT` returns to `ST_IDLE` on an edge with `in_valid` low.
- Synchronous reset forces `ST_IDLE` and clears every result field.

The block evaluates no flags, reads no registers and never fetches an indirect target value.

Top module: `brc_unit`

## Requirements
- R1: `out_valid` is high in the cycle after an edge on which `in_valid` was high, and low otherwise. Synchronous reset drives `out_valid` and all result fields to 0. Words keep streaming at one per cycle.
- R2: `out_direct` is set when the word's bits [27:25] are 101. When the top nibble is 1111, bits [31:25] must also equal 1111101.
- R3: For a direct branch, `out_target` equals the address plus 8 plus the sign-extended bits [23:0] shifted left by two, taken modulo 2^32. When the word is not a direct branch, `out_target` is 0.
- R4: For a direct branch whose top nibble is 1111, `out_target` bit 0 is forced to 1 to mark an instruction-set switch, and bit 1 takes word bit 24.
- R5: `out_link` is set for a direct branch with bit 24 set, for any direct branch whose top nibble is 1111, and for a register call where (word & 0x0FF000F0) == 0x01200030.
- R6: `out_indirect` is set, outside the 1111 top nibble, for each of these forms:
  - a register exchange, where (word & 0x0FF000D0) == 0x01200010;
  - the exchange variant with pattern 0x01200020 under mask 0x0FF000F0;
  - a load-multiple that loads the program counter, 0x08108000 under mask 0x0E108000;
  - a single load into the program counter, 0x0410F000 under mask 0x0E50F000 (immediate form) or 0x0610F000 under mask 0x0E50F010 (register form);
  - a move into the program counter, 0x01A0F000 under mask 0x0FE0F000;
  - a data-processing operation whose destination field [15:12] is 1111.

  Inside the 1111 top nibble, it is set only when (word & 0xFE500000) == 0xF8100000.
- R7: `out_return` is set, and only together with `out_indirect`, in four cases:
  - the register exchange with low byte 0x1E;
  - a load-multiple with (word & 0x0FFFA000) == 0x08BD8000;
  - an immediate load into the program counter with (word & 0x01FF0000) == 0x009D0000;
  - a move into the program counter with (word & 0x00100FFF) == 0x00E, which is the non-flag-setting, unshifted form with source register 14.
- R8: Test and compare data-processing forms with destination 1111, ((word & 0x0D90F000) == 0x0110F000), are never reported as indirect. The same holds for the miscellaneous, extended load/store and status-write-immediate groups.
- R9: `out_cond` is set exactly when word bits [31:29] are not all ones.
- R10: When bits [31:20] equal 0xF57, bits [7:4] select `out_barrier`: 4 gives 01 (data sync), 5 gives 10 (data memory), 6 gives 11 (instruction sync), and any other value gives 00 (none).
- R11: When (word & 0x0FFF0F00) == 0x0E070F00, the low byte selects `out_barrier`: 0x9A gives 01, 0xBA gives 10, 0x95 gives 11, and anything else gives 00.
- R12: In one result, a barrier, a direct branch and an indirect branch never coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The word and address on the inputs are to be classified |
| in_word | input | 32 | Instruction word |
| in_pc | input | 32 | Fetch address of the word |
| out_valid | output | 1 | Result fields belong to the word accepted on the previous edge |
| out_direct | output | 1 | Direct branch |
| out_indirect | output | 1 | Indirect branch |
| out_link | output | 1 | Call that saves a return address |
| out_return | output | 1 | Likely procedure return |
| out_cond | output | 1 | Word carries a condition other than always |
| out_barrier | output | 2 | 00 none, 01 data sync, 10 data memory, 11 instruction sync |
| out_target | output | 32 | Direct-branch destination, 0 when not direct |

## Verification
The bench targets the near-miss return encodings:
- A flag-setting move into the program counter is not a return. A design that ignored the S bit would call it one.
- A load-multiple from a base other than the stack pointer is not a return.
- A register call through the exchange pattern links but does not return.

It drives test and compare words with destination 1111 in both immediate and register forms. A decoder that kept only the immediate exclusion would flag the register form as indirect.

Direct targets are checked:
- for a backward offset;
- for a maximal forward offset that wraps past 2^32, which a truncated or unsigned adder gets wrong;
- for the two 1111-nibble forms, whose low target bits a design would leave clear if it skipped the switch marking.

Barrier selectors next to the valid codes, a bubble, and a back-to-back stream probe the emit machine's hold and transition behaviour.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int unsigned INSN_W = 32;

    typedef enum logic [1:0] {
        BAR_NONE  = 2'b00,
        BAR_DSYNC = 2'b01,
        BAR_DMEM  = 2'b10,
        BAR_ISYNC = 2'b11
    } bar_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } emit_state_e;

    typedef struct packed {
        logic      direct;
        logic      indirect;
        logic      link;
        logic      ret;
        logic      cond;
        bar_kind_e bar;
    } cls_flags_t;

    function automatic logic fmatch(input logic [INSN_W-1:0] w,
                                    input logic [INSN_W-1:0] mask,
                                    input logic [INSN_W-1:0] pat);
        return (w & mask) == pat;
    endfunction

endpackage

// File: rtl/brc_direct_dec.sv
module brc_direct_dec
    import brc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IMM_W    = 24,
    parameter int unsigned PIPE_OFS = 8
) (
    input  logic [INSN_W-1:0] word,
    input  logic [ADDR_W-1:0] pc,
    output logic              hit,
    output logic              link,
    output logic [ADDR_W-1:0] target
);
    localparam int unsigned PAD_W = ADDR_W - IMM_W - 2;

    logic              uncond_space;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        uncond_space = (word[INSN_W-1 -: 4] == 4'hF);
        if (uncond_space) begin
            hit = fmatch(word, 32'hFE00_0000, 32'hFA00_0000);
        end else begin
            hit = fmatch(word, 32'h0E00_0000, 32'h0A00_0000);
        end
        disp = {{PAD_W{word[IMM_W-1]}}, word[IMM_W-1:0], 2'b00};
        sum  = pc + ADDR_W'(PIPE_OFS) + disp;
        link = hit && (uncond_space || word[24]);
        if (!hit) begin
            target = '0;
        end else if (uncond_space) begin
            target = {sum[ADDR_W-1:2], word[24], 1'b1};
        end else begin
            target = sum;
        end
    end

endmodule

// File: rtl/brc_indirect_dec.sv
module brc_indirect_dec
    import brc_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output logic              hit,
    output logic              ret,
    output logic              reg_call
);
    always_comb begin
        hit      = 1'b0;
        ret      = 1'b0;
        reg_call = 1'b0;
        if (word[INSN_W-1 -: 4] == 4'hF) begin
            hit = fmatch(word, 32'hFE50_0000, 32'hF810_0000);
        end else if (fmatch(word, 32'h0FF0_00D0, 32'h0120_0010)) begin
            hit      = 1'b1;
            ret      = (word[7:0] == 8'h1E);
            reg_call = fmatch(word, 32'h0FF0_00F0, 32'h0120_0030);
        end else if (fmatch(word, 32'h0FF0_00F0, 32'h0120_0020)) begin
            hit = 1'b1;
        end else if (fmatch(word, 32'h0E10_8000, 32'h0810_8000)) begin
            hit = 1'b1;
            ret = fmatch(word, 32'h0FFF_A000, 32'h08BD_8000);
        end else if (fmatch(word, 32'h0E50_F000, 32'h0410_F000)) begin
            hit = 1'b1;
            ret = fmatch(word, 32'h01FF_0000, 32'h009D_0000);
        end else if (fmatch(word, 32'h0E50_F010, 32'h0610_F000)) begin
            hit = 1'b1;
        end else if (fmatch(word, 32'h0FE0_F000, 32'h01A0_F000)) begin
            hit = 1'b1;
            ret = fmatch(word, 32'h0010_0FFF, 32'h0000_000E);
        end else if (fmatch(word, 32'h0F90_0080, 32'h0100_0000)) begin
            hit = 1'b0;
        end else if (fmatch(word, 32'h0F90_00F0, 32'h0180_0090)) begin
            hit = 1'b0;
        end else if (fmatch(word, 32'h0FB0_F000, 32'h0320_F000)) begin
            hit = 1'b0;
        end else if (fmatch(word, 32'h0C00_F000, 32'h0000_F000)) begin
            hit = !fmatch(word, 32'h0D90_F000, 32'h0110_F000);
        end
    end

endmodule

// File: rtl/brc_aux_dec.sv
module brc_aux_dec
    import brc_pkg::*;
(
    input  logic [INSN_W-1:0] word,
    output logic              cond,
    output bar_kind_e         bar
);
    always_comb begin
        cond = (word[INSN_W-1 -: 3] != 3'b111);
        bar  = BAR_NONE;
        if (fmatch(word, 32'hFFF0_0000, 32'hF570_0000)) begin
            unique case (word[7:4])
                4'h4:    bar = BAR_DSYNC;
                4'h5:    bar = BAR_DMEM;
                4'h6:    bar = BAR_ISYNC;
                default: bar = BAR_NONE;
            endcase
        end else if (fmatch(word, 32'h0FFF_0F00, 32'h0E07_0F00)) begin
            unique case (word[7:0])
                8'h9A:   bar = BAR_DSYNC;
                8'hBA:   bar = BAR_DMEM;
                8'h95:   bar = BAR_ISYNC;
                default: bar = BAR_NONE;
            endcase
        end
    end

endmodule

// File: rtl/brc_unit.sv
module brc_unit
    import brc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned IMM_W    = 24,
    parameter int unsigned PIPE_OFS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [31:0]       in_word,
    input  logic [ADDR_W-1:0] in_pc,
    output logic              out_valid,
    output logic              out_direct,
    output logic              out_indirect,
    output logic              out_link,
    output logic              out_return,
    output logic              out_cond,
    output logic [1:0]        out_barrier,
    output logic [ADDR_W-1:0] out_target
);
    emit_state_e       state_q, state_d;
    cls_flags_t        flags_d, flags_q;
    logic [ADDR_W-1:0] target_d, target_q;

    logic      dir_hit, dir_link;
    logic      ind_hit, ind_ret, ind_call;
    logic      aux_cond;
    bar_kind_e aux_bar;

    brc_direct_dec #(
        .ADDR_W  (ADDR_W),
        .IMM_W   (IMM_W),
        .PIPE_OFS(PIPE_OFS)
    ) u_direct (
        .word  (in_word),
        .pc    (in_pc),
        .hit   (dir_hit),
        .link  (dir_link),
        .target(target_d)
    );

    brc_indirect_dec u_indirect (
        .word    (in_word),
        .hit     (ind_hit),
        .ret     (ind_ret),
        .reg_call(ind_call)
    );

    brc_aux_dec u_aux (
        .word(in_word),
        .cond(aux_cond),
        .bar (aux_bar)
    );

    always_comb begin
        flags_d.direct   = dir_hit;
        flags_d.indirect = ind_hit;
        flags_d.link     = dir_link | ind_call;
        flags_d.ret      = ind_ret;
        flags_d.cond     = aux_cond;
        flags_d.bar      = aux_bar;
    end

    // emit machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
        endcase
    end

    // emit machine: state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // result register
    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '0;
            target_q <= '0;
        end else if (in_valid) begin
            flags_q  <= flags_d;
            target_q <= target_d;
        end
    end

    assign out_valid    = (state_q == ST_EMIT);
    assign out_direct   = flags_q.direct;
    assign out_indirect = flags_q.indirect;
    assign out_link     = flags_q.link;
    assign out_return   = flags_q.ret;
    assign out_cond     = flags_q.cond;
    assign out_barrier  = flags_q.bar;
    assign out_target   = target_q;

endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_direct,
    input logic              out_indirect,
    input logic              out_link,
    input logic              out_return,
    input logic              out_cond,
    input logic [1:0]        out_barrier,
    input logic [ADDR_W-1:0] out_target
);
    a_r1_emit_after_accept: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_after_gap: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_target_zero_unless_direct: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_direct) |-> (out_target == '0));

    a_r4_switch_form_unconditional: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_direct && out_target[0]) |-> !out_cond);

    a_r5_link_needs_branch: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_link) |-> (out_direct || out_indirect));

    a_r7_return_is_indirect: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_return) |-> (out_indirect && !out_link));

    a_r12_exclusive_kinds: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0({out_direct, out_indirect, out_barrier != 2'b00}));

endmodule

bind brc_unit brc_checker #(.ADDR_W(ADDR_W)) u_brc_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_direct  (out_direct),
    .out_indirect(out_indirect),
    .out_link    (out_link),
    .out_return  (out_return),
    .out_cond    (out_cond),
    .out_barrier (out_barrier),
    .out_target  (out_target)
);

// File: tb/test_brc_unit.sv
module test_brc_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic [31:0] in_pc = '0;
    logic        out_valid, out_direct, out_indirect, out_link, out_return, out_cond;
    logic [1:0]  out_barrier;
    logic [31:0] out_target;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    brc_unit i_brc_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word), .in_pc(in_pc),
        .out_valid(out_valid), .out_direct(out_direct), .out_indirect(out_indirect),
        .out_link(out_link), .out_return(out_return), .out_cond(out_cond),
        .out_barrier(out_barrier), .out_target(out_target)
    );

    // {valid, direct, indirect, link, return, cond, barrier[1:0], target[31:0]}
    function automatic logic [39:0] ev(input logic d, input logic i, input logic l,
                                       input logic r, input logic c,
                                       input logic [1:0] b, input logic [31:0] t);
        return {1'b1, d, i, l, r, c, b, t};
    endfunction

    task automatic check(input string tag, input logic [39:0] exp);
        logic [39:0] act;
        act = {out_valid, out_direct, out_indirect, out_link, out_return, out_cond,
               out_barrier, out_target};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic present(input string tag, input logic [31:0] w, input logic [31:0] pc,
                           input logic [39:0] exp);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        in_pc    = pc;
        @(negedge clk);
        check(tag, exp);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset state", 40'h0);
    endtask

    task automatic t_direct();
        present("R2 R3 forward branch", 32'hEA00_0010, 32'h0000_1000,
                ev(1, 0, 0, 0, 0, 2'b00, 32'h0000_1048));
        present("R3 R5 R9 conditional backward call", 32'h0BFF_FFFE, 32'h0000_2000,
                ev(1, 0, 1, 0, 1, 2'b00, 32'h0000_2000));
        present("R3 wrap past 2^32", 32'hEA7F_FFFF, 32'hFFFF_FF00,
                ev(1, 0, 0, 0, 0, 2'b00, 32'h01FF_FF04));
    endtask

    task automatic t_mode_switch();
        present("R4 R5 switch form bit24=1", 32'hFB00_0004, 32'h0000_3000,
                ev(1, 0, 1, 0, 0, 2'b00, 32'h0000_301B));
        present("R4 R5 switch form bit24=0", 32'hFA00_0004, 32'h0000_3000,
                ev(1, 0, 1, 0, 0, 2'b00, 32'h0000_3019));
    endtask

    task automatic t_exchange();
        present("R6 R7 exchange to r14", 32'hE12F_FF1E, 32'h0,
                ev(0, 1, 0, 1, 0, 2'b00, 32'h0));
        present("R5 R7 register call not return", 32'hE12F_FF33, 32'h0,
                ev(0, 1, 1, 0, 0, 2'b00, 32'h0));
        present("R6 unconditional-space indirect", 32'hF810_0A00, 32'h0,
                ev(0, 1, 0, 0, 0, 2'b00, 32'h0));
    endtask

    task automatic t_loads();
        present("R7 load-multiple from stack", 32'hE8BD_8010, 32'h0,
                ev(0, 1, 0, 1, 0, 2'b00, 32'h0));
        present("R6 R7 load-multiple other base", 32'hE890_8000, 32'h0,
                ev(0, 1, 0, 0, 0, 2'b00, 32'h0));
        present("R7 load post-index stack", 32'hE49D_F004, 32'h0,
                ev(0, 1, 0, 1, 0, 2'b00, 32'h0));
    endtask

    task automatic t_move_pc();
        present("R7 plain move from r14", 32'hE1A0_F00E, 32'h0,
                ev(0, 1, 0, 1, 0, 2'b00, 32'h0));
        present("R7 flag-setting move not return", 32'hE1B0_F00E, 32'h0,
                ev(0, 1, 0, 0, 0, 2'b00, 32'h0));
        present("R6 move from r3", 32'hE1A0_F003, 32'h0,
                ev(0, 1, 0, 0, 0, 2'b00, 32'h0));
    endtask

    task automatic t_dp_exclusion();
        present("R8 compare immediate dest 1111", 32'hE350_F001, 32'h0,
                ev(0, 0, 0, 0, 0, 2'b00, 32'h0));
        present("R8 test register dest 1111", 32'hE110_F002, 32'h0,
                ev(0, 0, 0, 0, 0, 2'b00, 32'h0));
        present("R6 add register dest 1111", 32'hE080_F001, 32'h0,
                ev(0, 1, 0, 0, 0, 2'b00, 32'h0));
    endtask

    task automatic t_conditional();
        present("R9 conditional plain add", 32'h1280_0001, 32'h0,
                ev(0, 0, 0, 0, 1, 2'b00, 32'h0));
    endtask

    task automatic t_barrier_uncond();
        present("R10 data sync", 32'hF57F_F04F, 32'h0, ev(0, 0, 0, 0, 0, 2'b01, 32'h0));
        present("R10 data memory", 32'hF57F_F05F, 32'h0, ev(0, 0, 0, 0, 0, 2'b10, 32'h0));
        present("R10 instr sync", 32'hF57F_F06F, 32'h0, ev(0, 0, 0, 0, 0, 2'b11, 32'h0));
        present("R10 other selector", 32'hF57F_F01F, 32'h0, ev(0, 0, 0, 0, 0, 2'b00, 32'h0));
    endtask

    task automatic t_barrier_cop();
        present("R11 data sync", 32'hEE07_0F9A, 32'h0, ev(0, 0, 0, 0, 0, 2'b01, 32'h0));
        present("R11 data memory", 32'hEE07_0FBA, 32'h0, ev(0, 0, 0, 0, 0, 2'b10, 32'h0));
        present("R11 instr sync", 32'hEE07_0F95, 32'h0, ev(0, 0, 0, 0, 0, 2'b11, 32'h0));
        present("R11 other low byte", 32'hEE07_0F99, 32'h0, ev(0, 0, 0, 0, 0, 2'b00, 32'h0));
        present("R9 R11 conditional barrier", 32'h0E07_0F9A, 32'h0, ev(0, 0, 0, 0, 1, 2'b01, 32'h0));
    endtask

    task automatic t_bubble();
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = 32'hEA00_0010;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 bubble valid actual=%b expected=0", out_valid);
        end
    endtask

    task automatic t_stream();
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 32'hEA00_0000;
        in_pc    = 32'h0000_0100;
        @(negedge clk);
        check("R1 R3 stream first", ev(1, 0, 0, 0, 0, 2'b00, 32'h0000_0108));
        in_word = 32'hE12F_FF1E;
        @(negedge clk);
        check("R1 R7 stream second", ev(0, 1, 0, 1, 0, 2'b00, 32'h0));
        in_valid = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 stream end actual=%b expected=0", out_valid);
        end
    endtask

    task automatic t_reset_mid();
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 32'hFB00_0004;
        rst      = 1'b1;
        @(negedge clk);
        check("R1 reset clears result", 40'h0);
        rst      = 1'b0;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_mode_switch();
        t_exchange();
        t_loads();
        t_move_pc();
        t_dp_exclusion();
        t_conditional();
        t_barrier_uncond();
        t_barrier_cop();
        t_bubble();
        t_stream();
        t_reset_mid();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule